// File: doc/BRIEF.md
# External Interrupt Aggregation Controller

This block gathers seven external interrupt lines for an 8051-style processor core. Six of them come from a single event signal each: two general pins, a pulse input, a busy input, a status field and a falling-edge source. Each passes through a registered edge or change detector. The detected event sets a pending flag, and that flag is cleared when the core acknowledges the line's vector. Line 6 is shared by a group of peripheral sub-sources, such as a transfer-complete edge, timer ticks and an alarm. Each sub-source has its own sticky flag and its own enable. Line 6 is pending for as long as any enabled sub-flag is set.

Software reaches the block through a simple register-style write port: a write strobe, a 2-bit register select and an 8-bit data byte. Sub-flags are cleared by writing zeros, and written ones are ignored. A handler can therefore clear one flag by writing a mask of all ones except that bit. A sub-source event that lands during such a write is not lost. Each line drives a request output, which is its pending flag gated by its enable bit. The core, the priority logic and the pin multiplexing sit outside this block.

Top module: `exti_aggregator`

## Requirements
- R1: While reset is held and right after it is released with inputs idle, all request outputs, pending flags and sub-flags are 0, and all enables and edge selections are 0.
- R2: A rising edge on evt_pin_i[0] or evt_pin_i[1] sets pend_o[0] or pend_o[1] one clock later. A falling edge, or holding the level high, does not set it.
- R3: Register select 1 holds the edge selections, bit 0 for line 2 and bit 1 for line 3. With a selection of 0 (the intended setting), line 2 sets on a rising edge of pulse_i and line 3 sets on a falling edge of busy_i. With a selection of 1, each line sets on the opposite edge instead.
- R4: pend_o[4] sets one clock after any change in value of stat_i, and it does not set while stat_i is unchanged.
- R5: A falling edge on fall_src_i sets pend_o[5]. A rising edge on it does not.
- R6: A falling edge on sub_src_i[k] sets sub_flag_o[k], whatever the sub-enable bits hold. A sub-flag never clears except by a write.
- R7: A write to register select 3 clears each sub-flag whose data bit is 0 and leaves each sub-flag whose data bit is 1 unchanged, so an all-ones write changes nothing.
- R8: When a set event and a clear (a write to select 3, or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: ack_i[k] clears pend_o[k] for k = 0 to 5 one clock later. ack_i[6] has no effect.
- R10: pend_o[6] is 1 exactly when some bit of sub_flag_o is set together with its sub-enable bit. The sub-enables are written through register select 2, bit k for sub-source k.
- R11: irq_o[k] equals pend_o[k] AND line-enable bit k. The line enables are written through register select 0, bit k for line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 line enables, 1 edge selections, 2 sub-enables, 3 sub-flag clear) |
| wr_data_i | input | 8 | Write data byte |
| ack_i | input | 7 | Vector acknowledge, one bit per line |
| evt_pin_i | input | 2 | Event pins for lines 0 and 1 |
| pulse_i | input | 1 | Pulse source for line 2 |
| busy_i | input | 1 | Busy source for line 3 |
| stat_i | input | STAT_W | Status field watched by line 4 |
| fall_src_i | input | 1 | Falling-edge source for line 5 |
| sub_src_i | input | SUB_W | Falling-edge sub-sources shared on line 6 |
| irq_o | output | 7 | Enabled interrupt requests |
| pend_o | output | 7 | Pending flags |
| sub_flag_o | output | SUB_W | Sticky sub-source flags |

## Verification
The bench builds the block with STAT_W = 3 and SUB_W = 4, which makes every interesting space small enough to sweep in full. It covers all 64 status-field transitions, all 128 line-enable patterns, all 16 clear masks, and every pairing of the 16 sub-flag patterns with the 16 sub-enable patterns. It also tries all four edge-selection settings against both edge directions. The same-cycle races between a set and a write or an acknowledge are driven explicitly.

// File: rtl/exti_pkg.sv
package exti_pkg;
    localparam int LINE_CNT    = 7;
    localparam int SHARED_LINE = 6;
    localparam int PRIM_CNT    = LINE_CNT - 1;
    localparam int EDGE_CNT    = 5;
    localparam int REG_DW      = 8;
    localparam int REG_AW      = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_LINE_EN  = 2'd0,
        REG_EDGE_SEL = 2'd1,
        REG_SUB_EN   = 2'd2,
        REG_SUB_FLAG = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/exti_edge_det.sv
module exti_edge_det #(
    parameter int             W        = 1,
    parameter logic [W-1:0]   INV_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] evt_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t  st_d, st_q;
    logic [W-1:0] cond;

    // per-bit conditioning: selected sources are inverted before detection
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (INV_MASK[i]) begin : g_inv
                assign cond[i] = ~raw_i[i];
            end else begin : g_pass
                assign cond[i] = raw_i[i];
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond;
        evt_o     = (rise_sel_i & cond & ~st_q.prev)
                  | (~rise_sel_i & ~cond & st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/exti_change_det.sv
module exti_change_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val_i,
    output logic         evt_o
);
    typedef struct packed {
        logic [W-1:0] last;
    } chg_state_t;

    chg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = val_i;
        evt_o     = |(val_i ^ st_q.last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/exti_flag_reg.sv
module exti_flag_reg #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // a set arriving with a clear in one cycle takes precedence
    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
        flag_o    = st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/exti_aggregator.sv
module exti_aggregator
    import exti_pkg::*;
#(
    parameter int STAT_W = 3,
    parameter int SUB_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [REG_AW-1:0]    wr_addr_i,
    input  logic [REG_DW-1:0]    wr_data_i,
    input  logic [LINE_CNT-1:0]  ack_i,
    input  logic [1:0]           evt_pin_i,
    input  logic                 pulse_i,
    input  logic                 busy_i,
    input  logic [STAT_W-1:0]    stat_i,
    input  logic                 fall_src_i,
    input  logic [SUB_W-1:0]     sub_src_i,
    output logic [LINE_CNT-1:0]  irq_o,
    output logic [LINE_CNT-1:0]  pend_o,
    output logic [SUB_W-1:0]     sub_flag_o
);
    localparam logic [EDGE_CNT-1:0] EDGE_INV = 5'b10100;

    typedef struct packed {
        logic [LINE_CNT-1:0] line_en;
        logic [1:0]          edge_sel;
        logic [SUB_W-1:0]    sub_en;
    } ctrl_t;

    ctrl_t                ctl_d, ctl_q;
    logic [SUB_W-1:0]     sub_clr;
    logic [EDGE_CNT-1:0]  edge_raw, edge_rise, edge_evt;
    logic                 stat_evt;
    logic [PRIM_CNT-1:0]  prim_set, prim_pend;
    logic [SUB_W-1:0]     sub_set;
    logic                 unused_bits;

    always_comb begin
        ctl_d   = ctl_q;
        sub_clr = '0;
        if (wr_en_i) begin
            unique case (reg_sel_e'(wr_addr_i))
                REG_LINE_EN:  ctl_d.line_en  = wr_data_i[LINE_CNT-1:0];
                REG_EDGE_SEL: ctl_d.edge_sel = wr_data_i[1:0];
                REG_SUB_EN:   ctl_d.sub_en   = wr_data_i[SUB_W-1:0];
                REG_SUB_FLAG: sub_clr        = ~wr_data_i[SUB_W-1:0];
                default:      ctl_d          = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // lines 0,1,2,3,5 ; pulse and falling source inverted
    assign edge_raw  = {fall_src_i, busy_i, pulse_i, evt_pin_i};
    assign edge_rise = {1'b1, ctl_q.edge_sel[1], ctl_q.edge_sel[0], 2'b11};

    exti_edge_det #(.W(EDGE_CNT), .INV_MASK(EDGE_INV)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (edge_raw),
        .rise_sel_i (edge_rise),
        .evt_o      (edge_evt)
    );

    exti_change_det #(.W(STAT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .val_i (stat_i),
        .evt_o (stat_evt)
    );

    assign prim_set = {edge_evt[4], stat_evt, edge_evt[3:0]};

    exti_flag_reg #(.N(PRIM_CNT)) u_prim (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (prim_set),
        .clr_i  (ack_i[PRIM_CNT-1:0]),
        .flag_o (prim_pend)
    );

    exti_edge_det #(.W(SUB_W), .INV_MASK({SUB_W{1'b1}})) u_sub_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (sub_src_i),
        .rise_sel_i ({SUB_W{1'b1}}),
        .evt_o      (sub_set)
    );

    exti_flag_reg #(.N(SUB_W)) u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sub_set),
        .clr_i  (sub_clr),
        .flag_o (sub_flag_o)
    );

    assign pend_o      = {|(sub_flag_o & ctl_q.sub_en), prim_pend};
    assign irq_o       = pend_o & ctl_q.line_en;
    assign unused_bits = ^{wr_data_i, ack_i[SHARED_LINE]};
endmodule

// File: rtl/exti_aggregator_chk.sv
module exti_aggregator_chk #(
    parameter int SUB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [SUB_W-1:0] sub_wdata,
    input logic             ack0,
    input logic             ack6,
    input logic             pin0,
    input logic [6:0]       irq_o,
    input logic [6:0]       pend_o,
    input logic [SUB_W-1:0] sub_flag_o
);
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~pend_o) == 7'd0);

    assert_shared_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[6] |-> (sub_flag_o != '0));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o[0] && !pin0) |=> !pend_o[0]);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[0] && ack0 && !pin0) |=> !pend_o[0]);

    assert_shared_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[6] && ack6 && !wr_en_i) |=> pend_o[6]);

    assert_sub_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == 2'd3)
        |=> ((sub_flag_o & $past(sub_flag_o)) == $past(sub_flag_o)));

    assert_ones_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd3 && sub_wdata == '1)
        |=> ((sub_flag_o & $past(sub_flag_o)) == $past(sub_flag_o)));
endmodule

bind exti_aggregator exti_aggregator_chk #(.SUB_W(SUB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .sub_wdata  (wr_data_i[SUB_W-1:0]),
    .ack0       (ack_i[0]),
    .ack6       (ack_i[6]),
    .pin0       (evt_pin_i[0]),
    .irq_o      (irq_o),
    .pend_o     (pend_o),
    .sub_flag_o (sub_flag_o)
);

// File: tb/exti_aggregator_tb_top.sv
module exti_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 3;
    localparam int SUB_W      = 4;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [1:0]        wr_addr;
    logic [7:0]        wr_data;
    logic [6:0]        ack;
    logic [1:0]        pins;
    logic              pulse, busy, fsrc;
    logic [STAT_W-1:0] stat;
    logic [SUB_W-1:0]  sub;
    logic [6:0]        irq, pend;
    logic [SUB_W-1:0]  sflag;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exti_aggregator #(.STAT_W(STAT_W), .SUB_W(SUB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .ack_i(ack), .evt_pin_i(pins), .pulse_i(pulse),
        .busy_i(busy), .stat_i(stat), .fall_src_i(fsrc), .sub_src_i(sub),
        .irq_o(irq), .pend_o(pend), .sub_flag_o(sflag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_ack(input logic [6:0] m);
        ack = m;
        step();
        ack = '0;
    endtask

    task automatic load_sub(input logic [SUB_W-1:0] f);
        sub = ~f;
        step();
        sub = '1;
        step();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [5:0] cleared;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = '0;
        pins = '0; pulse = 1'b0; busy = 1'b1; fsrc = 1'b1; stat = '0; sub = '1;
        repeat (3) step();
        check("R1 pend in reset", pend, 0);
        check("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        step();
        check("R1 pend after reset", pend, 0);
        check("R1 subflags after reset", sflag, 0);
        check("R1 irq after reset", irq, 0);

        // set all primary lines 0..5 at once
        pins = 2'b11; pulse = 1'b1; busy = 1'b0; stat = 3'd1; fsrc = 1'b0;
        step();
        check("R2 R3 R4 R5 all primary set", pend, 7'h3F);
        pins = 2'b00; pulse = 1'b0; busy = 1'b1; stat = 3'd0; fsrc = 1'b1;
        step();
        check("R2 R5 return edges keep flags", pend, 7'h3F);

        // R11: all enable patterns
        for (int e = 0; e < 128; e++) begin
            wr(2'd0, 8'(e));
            check("R11 irq gating", irq, {1'b0, 6'(e)});
        end

        // R9: acknowledge one line at a time
        cleared = '0;
        for (int k = 0; k < 6; k++) begin
            do_ack(7'(1 << k));
            cleared[k] = 1'b1;
            check("R9 ack clears line", pend, {1'b0, ~cleared});
        end

        // R2: edge, hold, falling
        pins[0] = 1'b1; step();
        check("R2 rise sets", pend[0], 1);
        do_ack(7'h01);
        check("R2 ack while high", pend[0], 0);
        step();
        check("R2 level high no retrigger", pend[0], 0);
        pins[0] = 1'b0; step();
        check("R2 falling ignored", pend[0], 0);
        pins[1] = 1'b1; step();
        check("R2 pin1 rise sets", pend[1], 1);
        pins[1] = 1'b0; do_ack(7'h02);

        // R3: polarity sweep
        for (int p = 0; p < 4; p++) begin
            wr(2'd1, 8'(p));
            pulse = 1'b1; step();
            check("R3 line2 pulse rise", pend[2], !p[0]);
            do_ack(7'h04);
            pulse = 1'b0; step();
            check("R3 line2 pulse fall", pend[2], p[0]);
            do_ack(7'h04);
            busy = 1'b0; step();
            check("R3 line3 busy fall", pend[3], !p[1]);
            do_ack(7'h08);
            busy = 1'b1; step();
            check("R3 line3 busy rise", pend[3], p[1]);
            do_ack(7'h08);
        end
        wr(2'd1, 8'd0);

        // R4: every status transition
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                stat = 3'(a); step();
                do_ack(7'h10);
                stat = 3'(b); step();
                check("R4 status change", pend[4], (a != b));
            end
        end
        do_ack(7'h10);

        // R5
        fsrc = 1'b0; step();
        check("R5 falling sets", pend[5], 1);
        do_ack(7'h20);
        fsrc = 1'b1; step();
        check("R5 rising ignored", pend[5], 0);

        // R6: sub-flags accumulate and stay without enables
        for (int k = 0; k < SUB_W; k++) begin
            sub[k] = 1'b0; step();
            check("R6 sub fall sets", sflag, (1 << (k + 1)) - 1);
        end
        sub = '1; step();
        check("R6 sub rise ignored", sflag, 4'hF);
        check("R10 no enables no line6", pend[6], 0);

        // R7: every clear mask
        for (int m = 0; m < 16; m++) begin
            load_sub(4'hF);
            wr(2'd3, 8'hF0 | 8'(m));
            check("R7 write-zero clear", sflag, m);
        end

        // R10: all flag / enable pairings, line6 enabled only
        wr(2'd0, 8'h40);
        for (int en = 0; en < 16; en++) begin
            for (int f = 0; f < 16; f++) begin
                wr(2'd3, 8'h00);
                load_sub(4'(f));
                wr(2'd2, 8'(en));
                check("R10 line6 pending", pend[6], ((f & en) != 0));
                check("R11 line6 request", irq[6], ((f & en) != 0));
            end
        end
        do_ack(7'h40);
        check("R9 ack6 ignored", pend[6], 1);

        // R8: set beats clear write in same cycle
        wr(2'd3, 8'h00);
        sub[2] = 1'b0; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
        step();
        wr_en = 1'b0; sub = '1;
        check("R8 sub set wins", sflag, 4'b0100);
        step();

        // R8: set beats acknowledge
        pins[0] = 1'b1; step();
        pins[0] = 1'b0; step();
        pins[0] = 1'b1; ack = 7'h01; step();
        ack = '0;
        check("R8 pend set wins over ack", pend[0], 1);
        pins[0] = 1'b0; step();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule